// File: doc/BRIEF.md
# Configuration Bitstream Loader

This block sits on a memory-mapped register bus and feeds a configuration image to downstream configurable devices. Software writes the image length in bytes, enables the block, and then pushes 32-bit words into a single data window, either by CPU stores or by a DMA engine answering the block's request line. The block queues the words in an internal FIFO and sends each one as four bytes, most significant byte first, over a ready/valid byte interface toward the target.

A current byte counter advances on every byte the target accepts. Once all expected bytes have gone out, the block waits for the target's config-done input. Programming ends, and the completion interrupt rises, on config-done, on a target error, on a lost data word, or when config-done fails to arrive in time. Writing the control register with enable clear drops the interrupt and flushes the FIFO. Software can also hold a reset line toward the targets by setting enable and reset together, then writing zero.

Top module: `cfg_loader`

## Requirements
- R1: After reset `irq`, `tgt_valid`, `dma_req` and `tgt_reset` are low, the status register (0x44) reads 0 and the capacity register (0x48) reads 4*DEPTH.
- R2: The head word goes out as four bytes, bits 31:24 first and bits 7:0 last; a byte is held stable while `tgt_ready` is low, and the current count (0x54) rises by one for each byte accepted.
- R3: The occupancy register (0x4C) reads the number of queued bytes not yet accepted by the target: 4 per stored word, less the bytes already sent from the head word, and 0 when the FIFO is empty.
- R4: A write to the data window (0x3000) while the FIFO holds DEPTH words or while enable (control bit 0) is clear is dropped and sets status bit 1; if enable is set, it also ends programming with the interrupt.
- R5: No byte is offered once the current count equals the total count (0x50).
- R6: When the current count equals the total count and `tgt_done` is high, `irq` rises on the next clock and status bit 0 is set; status bit 18 mirrors `tgt_done`.
- R7: If `tgt_done` stays low for DONE_WAIT cycles after the last byte, status bit 3 and `irq` are set.
- R8: `tgt_err` high while programming sets status bit 2, raises `irq` and stops the byte stream.
- R9: Writing the control register (0x40) with bit 0 clear lowers `irq` on the next clock and empties the FIFO.
- R10: Writing the control register with bit 0 set while it was clear zeroes the current count and status bits 3:1.
- R11: With control bit 2 set, `dma_req` is high while programming, the FIFO has room for at least DEPTH/2 words, and the bytes sent plus the bytes queued are fewer than the total; with control bit 2 clear it stays low.
- R12: `tgt_reset` is high exactly while control bits 0 and 1 are both set, and no byte is offered meanwhile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register or data window write strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| dma_req | output | 1 | Request for a DEPTH/2-word burst |
| irq | output | 1 | Programming-ended interrupt |
| tgt_data | output | 8 | Configuration byte toward the target |
| tgt_valid | output | 1 | `tgt_data` is valid |
| tgt_ready | input | 1 | Target accepts the byte |
| tgt_done | input | 1 | Target reports configuration complete |
| tgt_err | input | 1 | Target reports a configuration error |
| tgt_reset | output | 1 | Deconfiguring reset toward the target |

## Verification
The assertions assume at most one bus access per cycle and that the total count is not rewritten while a byte is waiting on `tgt_ready`, so a held byte can only be dropped by a control write or a target error. The stimulus keeps to that: every register access is a single-cycle write driven at the falling edge, the total is set before enabling, and `tgt_done` and `tgt_err` are pulsed only when the test targets success, timeout or error. DMA bursts are played by the bench itself, writing DEPTH/2 words whenever it sees the request.

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int DEPTH     = 16,
  parameter int CNT_W     = 32,
  parameter int DONE_WAIT = 1000,
  parameter int ADDR_W    = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              dma_req,
  output logic              irq,
  output logic [7:0]        tgt_data,
  output logic              tgt_valid,
  input  logic              tgt_ready,
  input  logic              tgt_done,
  input  logic              tgt_err,
  output logic              tgt_reset
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int UW    = PTR_W + 3;
  localparam int TW    = $clog2(DONE_WAIT + 1);
  localparam int CAP_BYTES = DEPTH * 4;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'('h44);
  localparam logic [ADDR_W-1:0] A_CAP   = ADDR_W'('h48);
  localparam logic [ADDR_W-1:0] A_USED  = ADDR_W'('h4C);
  localparam logic [ADDR_W-1:0] A_TOTAL = ADDR_W'('h50);
  localparam logic [ADDR_W-1:0] A_CUR   = ADDR_W'('h54);
  localparam logic [ADDR_W-1:0] A_FIFO  = ADDR_W'('h3000);

  logic en, rst_bit, dma_mode, irq_q;
  logic err_ovf, err_tgt, err_tmo;
  logic [31:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [PTR_W:0] cnt;
  logic [1:0] idx;
  logic [CNT_W-1:0] cur, total;
  logic [TW-1:0] tmr;

  wire ctrl_wr  = bus_wr && bus_addr == A_CTRL;
  wire total_wr = bus_wr && bus_addr == A_TOTAL;
  wire fifo_wr  = bus_wr && bus_addr == A_FIFO;
  wire full     = cnt == (PTR_W+1)'(DEPTH);
  wire empty    = cnt == '0;
  wire active   = en && !rst_bit && !irq_q;
  wire push     = fifo_wr && en && !full;
  wire drop     = fifo_wr && !push;
  wire at_end   = cur == total;
  wire fire     = tgt_valid && tgt_ready;
  wire pop      = fire && idx == 2'd3;
  wire en_rise  = ctrl_wr && bus_wdata[0] && !en;

  wire [31:0]   head       = mem[rp];
  wire [UW-1:0] used_bytes = {cnt, 2'b00} - UW'(idx);
  wire [CNT_W-1:0] supplied = cur + CNT_W'(used_bytes);

  wire done_hit = active && at_end && tgt_done;
  wire tmo_hit  = active && at_end && !tgt_done && tmr == TW'(DONE_WAIT - 1);
  wire terr_hit = active && tgt_err;

  assign tgt_valid = active && !empty && !at_end;
  assign tgt_data  = head[{~idx, 3'b000} +: 8];
  assign dma_req   = active && dma_mode && cnt <= (PTR_W+1)'(DEPTH/2) && supplied < total;
  assign irq       = irq_q;
  assign tgt_reset = en && rst_bit;

  always_ff @(posedge clk)
    if (push) mem[wp] <= bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {en, rst_bit, dma_mode, irq_q} <= '0;
      {err_ovf, err_tgt, err_tmo} <= '0;
      wp <= '0; rp <= '0; cnt <= '0; idx <= '0;
      cur <= '0; total <= '0; tmr <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
      if (fire) begin
        idx <= idx + 2'd1;
        cur <= cur + 1'b1;
      end
      tmr <= (active && at_end && !tgt_done) ? tmr + 1'b1 : '0;
      if (total_wr) total <= bus_wdata[CNT_W-1:0];
      if (drop)     err_ovf <= 1'b1;
      if (terr_hit) err_tgt <= 1'b1;
      if (tmo_hit)  err_tmo <= 1'b1;
      if (done_hit || tmo_hit || terr_hit || (drop && en)) irq_q <= 1'b1;
      if (ctrl_wr) begin
        {dma_mode, rst_bit, en} <= bus_wdata[2:0];
        if (!bus_wdata[0]) begin
          irq_q <= 1'b0;
          wp <= '0; rp <= '0; cnt <= '0; idx <= '0;
        end
        if (en_rise) begin
          {err_ovf, err_tgt, err_tmo} <= '0;
          cur <= '0;
          tmr <= '0;
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {29'b0, dma_mode, rst_bit, en};
      A_STAT:  bus_rdata = {13'b0, tgt_done, 14'b0, err_tmo, err_tgt, err_ovf, irq_q};
      A_CAP:   bus_rdata = 32'(CAP_BYTES);
      A_USED:  bus_rdata = 32'(used_bytes);
      A_TOTAL: bus_rdata = 32'(total);
      A_CUR:   bus_rdata = 32'(cur);
      default: bus_rdata = '0;
    endcase
  end

  p_hold_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid && !tgt_ready && !tgt_err && !bus_wr |=> tgt_valid && $stable(tgt_data));
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cur == $past(cur) + 1'b1);
  p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    used_bytes <= UW'(CAP_BYTES));
  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !bus_wdata[0] |=> !irq && used_bytes == '0);
  p_dma_room_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> cnt <= (PTR_W+1)'(DEPTH/2));
  p_quiet_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_reset |-> !tgt_valid && !dma_req);
endmodule

// File: tb/cfg_loader_test.sv
`timescale 1ns/1ps
module cfg_loader_test;
  localparam int DEPTH = 16;
  localparam int WAIT  = 20;
  localparam logic [31:0] VEC [6] = '{32'h0123_4567, 32'h89AB_CDEF, 32'hFF00_FF00,
                                      32'h00FF_00FF, 32'hA5C3_3C5A, 32'h8000_0001};

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic dma_req, irq, tgt_valid, tgt_reset;
  logic [7:0] tgt_data;
  logic tgt_ready = 0, tgt_done = 0, tgt_err = 0;
  int n_chk = 0, n_bad = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  cfg_loader #(.DEPTH(DEPTH), .DONE_WAIT(WAIT)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_req(dma_req), .irq(irq),
    .tgt_data(tgt_data), .tgt_valid(tgt_valid), .tgt_ready(tgt_ready),
    .tgt_done(tgt_done), .tgt_err(tgt_err), .tgt_reset(tgt_reset));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs", {28'b0, irq, tgt_valid, dma_req, tgt_reset}, 0);
    rd(14'h44, v); chk("R1 status", v, 0);
    rd(14'h48, v); chk("R1 capacity", v, DEPTH * 4);

    // R12 reset pulse
    wr(14'h40, 3); chk("R12 pulse high", {31'b0, tgt_reset}, 1);
    wr(14'h40, 0); chk("R12 pulse low", {31'b0, tgt_reset}, 0);

    // R4 write while disabled
    wr(14'h3000, 32'hDEAD_BEEF);
    rd(14'h44, v); chk("R4 disabled drop flag", v, 2);
    rd(14'h4C, v); chk("R4 disabled drop occupancy", v, 0);
    chk("R4 no irq when disabled", {31'b0, irq}, 0);

    // Main CPU-fed stream
    wr(14'h50, 24);
    wr(14'h40, 1);
    rd(14'h44, v); chk("R10 errors cleared", v, 0);
    for (int k = 0; k < 6; k++) wr(14'h3000, VEC[k]);
    rd(14'h4C, v); chk("R3 occupancy full words", v, 24);
    chk("R2 first byte MSB", {24'b0, tgt_data}, {24'b0, VEC[0][31:24]});
    repeat (2) @(negedge clk);
    chk("R2 held while not ready", {23'b0, tgt_valid, tgt_data}, {23'b0, 1'b1, VEC[0][31:24]});
    rd(14'h54, v); chk("R2 no count without ready", v, 0);
    tgt_ready = 1; @(negedge clk); tgt_ready = 0;
    rd(14'h4C, v); chk("R3 partial head word", v, 23);
    rd(14'h54, v); chk("R2 count after one byte", v, 1);
    tgt_ready = 1;
    for (int k = 1; k < 24; k++) begin
      v = VEC[k/4] >> (24 - 8 * (k % 4));
      chk("R2 byte order", {23'b0, tgt_valid, tgt_data}, {23'b0, 1'b1, v[7:0]});
      @(negedge clk);
    end
    chk("R5 stop at total", {31'b0, tgt_valid}, 0);
    tgt_ready = 0;
    rd(14'h54, v); chk("R2 final count", v, 24);
    chk("R6 no irq before done", {31'b0, irq}, 0);
    tgt_done = 1; @(negedge clk);
    chk("R6 irq on done", {31'b0, irq}, 1);
    rd(14'h44, v); chk("R6 status done", v, 32'h0004_0001);
    wr(14'h40, 0); tgt_done = 0;
    chk("R9 irq cleared", {31'b0, irq}, 0);

    // R4 overflow when full
    wr(14'h50, 100);
    wr(14'h40, 1);
    rd(14'h54, v); chk("R10 count cleared", v, 0);
    for (int k = 0; k < DEPTH; k++) wr(14'h3000, k);
    chk("R4 no irq while room", {31'b0, irq}, 0);
    wr(14'h3000, 32'h1234_5678);
    rd(14'h44, v); chk("R4 full drop flag", v, 3);
    rd(14'h4C, v); chk("R4 full occupancy unchanged", v, DEPTH * 4);
    chk("R4 irq on drop", {31'b0, irq}, 1);
    wr(14'h40, 0);
    rd(14'h4C, v); chk("R9 fifo flushed", v, 0);

    // R7 timeout
    wr(14'h50, 4);
    wr(14'h40, 1);
    wr(14'h3000, 32'h1122_3344);
    tgt_ready = 1;
    repeat (6) @(negedge clk);
    tgt_ready = 0;
    rd(14'h54, v); chk("R7 all bytes sent", v, 4);
    chk("R7 no irq yet", {31'b0, irq}, 0);
    repeat (WAIT + 5) @(negedge clk);
    chk("R7 irq on timeout", {31'b0, irq}, 1);
    rd(14'h44, v); chk("R7 status timeout", v, 9);

    // R8 target error
    wr(14'h40, 0);
    wr(14'h50, 8);
    wr(14'h40, 1);
    wr(14'h3000, 32'hCAFE_F00D);
    wr(14'h3000, 32'h0BAD_0BAD);
    chk("R8 streaming before error", {31'b0, tgt_valid}, 1);
    tgt_err = 1; @(negedge clk); tgt_err = 0;
    chk("R8 irq and stop", {30'b0, irq, tgt_valid}, 2);
    rd(14'h44, v); chk("R8 status error", v, 5);

    // R11 DMA request
    wr(14'h40, 0);
    wr(14'h50, 32);
    wr(14'h40, 1);
    chk("R11 no request in CPU mode", {31'b0, dma_req}, 0);
    wr(14'h40, 0);
    wr(14'h40, 5);
    chk("R11 request with room", {31'b0, dma_req}, 1);
    for (int k = 0; k < DEPTH / 2; k++) wr(14'h3000, 32'h5000_0000 + k);
    chk("R11 request drops at total", {31'b0, dma_req}, 0);
    rd(14'h4C, v); chk("R11 burst queued", v, 32);
    tgt_ready = 1;
    repeat (34) @(negedge clk);
    rd(14'h54, v); chk("R11 burst streamed", v, 32);
    tgt_done = 1; @(negedge clk);
    chk("R6 irq after DMA run", {31'b0, irq}, 1);
    tgt_done = 0; tgt_ready = 0;
    wr(14'h40, 0);

    finish_run();
  end
endmodule